// File: doc/BRIEF.md
# Receive Character Recognition Matcher

This block sits behind one channel of an asynchronous serial receiver and inspects every character the receiver delivers. Each delivered byte is compared at once against three programmable match characters. A hit on a slot sets that slot's sticky status bit and a sticky summary bit. The status bits feed a maskable interrupt request.

Each slot also carries a two-bit mode that picks a side action. In interrupt-only mode the slot just reports. In pause or resume mode the slot drives in-band software flow control: a pause hit halts the local transmitter through a pause flag, and a resume hit releases it. In address mode the slot acts as the station-address compare for nine-bit multidrop links. It only hits on characters whose ninth bit is set, and it maintains an address-matched flag that the receive path uses to accept or drop the frames that follow.

The host clears status bits by pulsing write-one-to-clear inputs. The character match values, the slot modes and the interrupt mask are static configuration inputs.

Top module: `char_match_top`

## Requirements
- R1: While rst_ni is low, and after it is released with no further stimulus, match_status_o, summary_o, irq_o, tx_pause_o and addr_match_o are all 0.
- R2: In a cycle with rx_valid_i=1, slot k hits when rx_data_i equals match_chars_i[8k+7:8k]. Its status bit match_status_o[k] is 1 from the next rising clock edge.
- R3: Slot k's mode is slot_mode_i[2k+1:2k], encoded 0 interrupt-only, 1 pause, 2 resume, 3 address. An address-mode slot hits only when rx_addr_bit_i=1. The other modes compare the byte whatever the ninth bit is.
- R4: summary_o is set on the edge after any slot hits. It stays set until a summary_clr_i pulse clears it. A hit in the same cycle as the clear leaves it set.
- R5: Status bits are sticky. status_clr_i[k]=1 clears bit k on the next edge, unless slot k hits in that same cycle, in which case the bit stays 1.
- R6: irq_o equals the OR of match_status_o AND irq_mask_i. It follows a mask change in the same cycle, with no added clock.
- R7: A pause-mode hit sets tx_pause_o on the next edge. A resume-mode hit with no pause-mode hit clears it. When both hit the same character, tx_pause_o is set.
- R8: A valid character with rx_addr_bit_i=1 updates addr_match_o only when at least one slot is in address mode. The flag becomes 1 if an address-mode slot hits and 0 otherwise.
- R9: When several slots hit the same character, all of their status bits are set on the same edge.
- R10: A cycle with rx_valid_i=0 changes no status bit, summary_o, tx_pause_o or addr_match_o, whatever rx_data_i holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 8 | Received character |
| rx_valid_i | input | 1 | One-cycle strobe marking a new character |
| rx_addr_bit_i | input | 1 | Ninth (address) bit of the character |
| match_chars_i | input | 24 | Three match characters, slot k in bits [8k+7:8k] |
| slot_mode_i | input | 6 | Slot modes, slot k in bits [2k+1:2k] |
| status_clr_i | input | 3 | Write-one-to-clear pulses for the status bits |
| summary_clr_i | input | 1 | Clear pulse for the summary bit |
| irq_mask_i | input | 3 | Interrupt enable per slot |
| match_status_o | output | 3 | Sticky per-slot hit bits |
| summary_o | output | 1 | Sticky any-hit bit |
| irq_o | output | 1 | Interrupt request |
| tx_pause_o | output | 1 | Transmit pause flag |
| addr_match_o | output | 1 | Multidrop address accepted flag |

## Verification
The bench builds the block with its defaults: 8-bit characters and three slots. Three slots are enough to place a pause, a resume and an address slot side by side, and also to load all three with one character so they hit together. The directed phases set up the pause-and-resume collision, the clear-and-hit collision and ninth-bit filtering. A random phase then draws characters mostly from the loaded match values, with random ninth bits, modes, masks and clears, so that slot collisions and clears that land on a hit happen often.

// File: rtl/cm_pkg.sv
package cm_pkg;
  localparam int unsigned MODE_W = 2;
  typedef enum logic [MODE_W-1:0] {
    SLOT_IRQ  = 2'd0,
    SLOT_XOFF = 2'd1,
    SLOT_XON  = 2'd2,
    SLOT_ADDR = 2'd3
  } slot_mode_e;
endpackage

// File: rtl/cm_slot_cmp.sv
module cm_slot_cmp
  import cm_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              valid_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              addr_bit_i,
  input  logic [DATA_W-1:0] ref_i,
  input  logic [MODE_W-1:0] mode_i,
  output logic              hit_o,
  output logic              xoff_hit_o,
  output logic              xon_hit_o,
  output logic              addr_hit_o,
  output logic              addr_slot_o
);
  logic eq;
  logic is_addr;

  assign eq          = (data_i == ref_i);
  assign is_addr     = (mode_i == SLOT_ADDR);
  // address slots only qualify on ninth-bit characters
  assign hit_o       = valid_i && eq && (!is_addr || addr_bit_i);
  assign xoff_hit_o  = hit_o && (mode_i == SLOT_XOFF);
  assign xon_hit_o   = hit_o && (mode_i == SLOT_XON);
  assign addr_hit_o  = hit_o && is_addr;
  assign addr_slot_o = is_addr;
endmodule

// File: rtl/cm_sticky_reg.sv
module cm_sticky_reg #(
  parameter int unsigned W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= '0;
    else         q_o <= (q_o & ~clr_i) | set_i;  // set beats clear
  end

  // R5
  set_sticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> ((q_o & $past(set_i)) == $past(set_i)));
  // R10
  no_spurious_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i == '0) |=> ((q_o & ~$past(q_o)) == '0));
  // R5
  clr_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((clr_i & ~set_i) != '0) |=> ((q_o & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/cm_flow_ctl.sv
module cm_flow_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic valid_i,
  input  logic addr_bit_i,
  input  logic xoff_hit_i,
  input  logic xon_hit_i,
  input  logic addr_hit_i,
  input  logic addr_armed_i,
  output logic tx_pause_o,
  output logic addr_match_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_pause_o   <= 1'b0;
      addr_match_o <= 1'b0;
    end else begin
      if (xoff_hit_i)     tx_pause_o <= 1'b1;
      else if (xon_hit_i) tx_pause_o <= 1'b0;
      if (valid_i && addr_bit_i && addr_armed_i) addr_match_o <= addr_hit_i;
    end
  end

  // R7
  pause_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xoff_hit_i |=> tx_pause_o);
  // R7
  pause_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (xon_hit_i && !xoff_hit_i) |=> !tx_pause_o);
  // R8
  addr_accept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    addr_hit_i |=> addr_match_o);
  // R10
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(tx_pause_o) && $stable(addr_match_o)));
endmodule

// File: rtl/char_match_top.sv
module char_match_top
  import cm_pkg::*;
#(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned NUM_SLOTS = 3
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [DATA_W-1:0]           rx_data_i,
  input  logic                        rx_valid_i,
  input  logic                        rx_addr_bit_i,
  input  logic [NUM_SLOTS*DATA_W-1:0] match_chars_i,
  input  logic [NUM_SLOTS*MODE_W-1:0] slot_mode_i,
  input  logic [NUM_SLOTS-1:0]        status_clr_i,
  input  logic                        summary_clr_i,
  input  logic [NUM_SLOTS-1:0]        irq_mask_i,
  output logic [NUM_SLOTS-1:0]        match_status_o,
  output logic                        summary_o,
  output logic                        irq_o,
  output logic                        tx_pause_o,
  output logic                        addr_match_o
);
  logic [NUM_SLOTS-1:0] hit, xoff_hit, xon_hit, addr_hit, addr_slot;

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    cm_slot_cmp #(.DATA_W(DATA_W)) u_cmp (
      .valid_i    (rx_valid_i),
      .data_i     (rx_data_i),
      .addr_bit_i (rx_addr_bit_i),
      .ref_i      (match_chars_i[k*DATA_W +: DATA_W]),
      .mode_i     (slot_mode_i[k*MODE_W +: MODE_W]),
      .hit_o      (hit[k]),
      .xoff_hit_o (xoff_hit[k]),
      .xon_hit_o  (xon_hit[k]),
      .addr_hit_o (addr_hit[k]),
      .addr_slot_o(addr_slot[k])
    );
  end

  cm_sticky_reg #(.W(NUM_SLOTS)) u_status (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (hit),
    .clr_i (status_clr_i),
    .q_o   (match_status_o)
  );

  cm_sticky_reg #(.W(1)) u_summary (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (|hit),
    .clr_i (summary_clr_i),
    .q_o   (summary_o)
  );

  cm_flow_ctl u_flow (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .valid_i     (rx_valid_i),
    .addr_bit_i  (rx_addr_bit_i),
    .xoff_hit_i  (|xoff_hit),
    .xon_hit_i   (|xon_hit),
    .addr_hit_i  (|addr_hit),
    .addr_armed_i(|addr_slot),
    .tx_pause_o  (tx_pause_o),
    .addr_match_o(addr_match_o)
  );

  assign irq_o = |(match_status_o & irq_mask_i);

  // R4
  summary_tracks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_status_o != $past(match_status_o)) && ((match_status_o & ~$past(match_status_o)) != '0)
      |-> summary_o);
  // R9
  all_hits_land_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit != '0) |=> ((match_status_o & $past(hit)) == $past(hit)));
endmodule

// File: tb/sim_char_match_top.sv
module sim_char_match_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 3;

  logic clk = 0, rst_n = 0;
  logic [7:0] rx_data = 0;
  logic rx_valid = 0, rx_abit = 0;
  logic [23:0] chars = 0;
  logic [5:0] modes = 0;
  logic [2:0] sclr = 0, mask = 0;
  logic mclr = 0;
  logic [2:0] status;
  logic summary, irq, pause, amatch;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  string phase = "R1 reset";

  // reference state
  bit [2:0] m_stat;
  bit m_sum, m_pause, m_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  char_match_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .rx_data_i(rx_data), .rx_valid_i(rx_valid),
    .rx_addr_bit_i(rx_abit), .match_chars_i(chars), .slot_mode_i(modes),
    .status_clr_i(sclr), .summary_clr_i(mclr), .irq_mask_i(mask),
    .match_status_o(status), .summary_o(summary), .irq_o(irq),
    .tx_pause_o(pause), .addr_match_o(amatch)
  );

  // behavioural model: R2 R3 R4 R5 R7 R8 R9 R10
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_stat = 0; m_sum = 0; m_pause = 0; m_addr = 0;
    end else begin
      bit [2:0] h;
      bit xo, xn, ah, armed;
      h = 0; xo = 0; xn = 0; ah = 0; armed = 0;
      for (int k = 0; k < N; k++) begin
        int md;
        md = modes[2*k +: 2];
        if (md == 3) armed = 1;
        if (rx_valid && rx_data == chars[8*k +: 8] && (md != 3 || rx_abit)) begin
          h[k] = 1;
          if (md == 1) xo = 1;
          if (md == 2) xn = 1;
          if (md == 3) ah = 1;
        end
      end
      m_stat = (m_stat & ~sclr) | h;
      m_sum  = (m_sum & ~mclr) | (h != 0);
      if (xo) m_pause = 1; else if (xn) m_pause = 0;
      if (rx_valid && rx_abit && armed) m_addr = ah;
    end
  end

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s [%s] actual=%0h expected=%0h t=%0t", tag, phase, act, exp, $time);
    end
  endtask

  // compare on every falling edge
  always @(negedge clk) if (rst_n && !done) begin
    chk("R2", status, m_stat);
    chk("R4", summary, m_sum);
    chk("R6", irq, |(m_stat & mask));
    chk("R7", pause, m_pause);
    chk("R8", amatch, m_addr);
  end

  task automatic step(bit v, bit [7:0] d, bit a, bit [2:0] sc = 0, bit mc = 0);
    @(negedge clk); #1;
    rx_valid = v; rx_data = d; rx_abit = a; sclr = sc; mclr = mc;
  endtask

  task automatic summary_out();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    summary_out();
  end

  initial begin
    chars = {8'h42, 8'h11, 8'h13};
    modes = {2'd3, 2'd2, 2'd1};
    mask = 3'b111;
    repeat (3) @(negedge clk);
    // R1
    chk("R1", {status, summary, irq, pause, amatch}, 0);
    #1 rst_n = 1;
    step(0, 0, 0);
    @(negedge clk); #2;
    chk("R1", {status, summary, irq, pause, amatch}, 0);

    phase = "R7 pause"; step(1, 8'h13, 0); step(0, 0, 0);
    phase = "R10 idle"; step(0, 8'h11, 0); step(0, 8'h42, 1);
    phase = "R7 resume"; step(1, 8'h11, 1); step(0, 0, 0);
    phase = "R3 ninth bit low"; step(1, 8'h42, 0, 3'b111, 1); step(0, 0, 0);
    phase = "R8 address hit"; step(1, 8'h42, 1); step(0, 0, 0);
    phase = "R8 address miss"; step(1, 8'h55, 1); step(0, 0, 0);
    phase = "R5 clear vs hit"; step(1, 8'h13, 0, 3'b111, 1); step(0, 0, 0);
    phase = "R6 mask"; step(0, 0, 0); @(negedge clk); #1 mask = 3'b010; step(0, 0, 0);
    #1 mask = 3'b001; step(0, 0, 0, 3'b111, 1);
    phase = "R9 triple hit"; step(0, 0, 0); #1 chars = {3{8'h7e}}; modes = 0; mask = 3'b111;
    step(1, 8'h7e, 0); step(0, 0, 0);
    phase = "R7 pause and resume together"; #1 modes = {2'd0, 2'd2, 2'd1};
    step(1, 8'h7e, 0); step(0, 0, 0);

    phase = "random R2 R3 R4 R5 R6 R7 R8 R9 R10";
    for (int i = 0; i < 4000; i++) begin
      bit [7:0] d;
      @(negedge clk); #1;
      if (i % 200 == 0) begin
        for (int k = 0; k < N; k++) chars[8*k +: 8] = 8'($urandom_range(0, 7));
        modes = 6'($urandom);
      end
      mask = 3'($urandom);
      d = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'($urandom_range(0, 7));
      rx_valid = $urandom_range(0, 2) != 0; rx_data = d; rx_abit = 1'($urandom);
      sclr = ($urandom_range(0, 3) == 0) ? 3'($urandom) : 3'b0;
      mclr = $urandom_range(0, 5) == 0;
    end
    step(0, 0, 0);
    @(negedge clk); @(negedge clk);
    summary_out();
  end
endmodule